// File: doc/BRIEF.md
# Management Frame Port with Embedded PHY Register Model

The block is a host-visible management frame register that runs one whole PHY management transaction for each host write to it. A written frame carries start, operation, PHY-address and register-address fields plus a 16-bit data field. When the frame is well formed and aimed at the embedded PHY, the block either loads the data into one of 32 sixteen-bit PHY registers or replaces the frame's data field with that register's contents. It then stores the frame with the low turnaround bit set, which tells the host the transaction is done. A read of the frame issued in the cycle after the write already returns the finished value.

The embedded PHY mimics a small transceiver. A write to its control register clears its reset and restart-negotiation bits by itself. It also reports negotiation completion and, when the link is up, link status and partner 100 Mb/s full-duplex ability. Alongside the frame register there are two more host registers. The first is a configuration register with two bits the host cannot change. The second is a management status register. It is loaded with all ones whenever the `link_up` input changes, and a host read clears it.

Top module: `mgmt_frame_port`

## Requirements
- R1: After a synchronous reset the frame register reads 0 and the configuration register reads 0x100. The management status register reads 0. PHY register 4 holds 0x0100, register 1 holds 0x4028 (plus 0x0004 if `link_up` is high), register 5 holds 0x0100 if `link_up` is high and 0 otherwise, and registers 2 and 3 hold the identifier parameters.
- R2: The frame layout is start [31:30], operation [29:28], PHY address [27:23], register address [22:18], turnaround [17:16] and data [15:0]. A frame whose start field is not 01 is stored with bit 16 forced to 1, and no PHY register changes.
- R3: A frame with start 01 whose PHY address is not `PHY_ADDR` (default 1) is stored with bit 16 set, and no PHY register changes.
- R4: A valid frame with operation 01 writes its data field into the addressed PHY register and is stored with bit 16 set.
- R5: A valid frame with operation 10 is stored with its data field replaced by the addressed PHY register, with bit 16 set. A frame read one cycle after the write returns this value.
- R6: A valid frame with operation 00 or 11 is stored with bit 16 set, and no PHY register changes.
- R7: A write to PHY register 0 with bit 15 set stores the value with bit 15 cleared and bit 12 set.
- R8: A write to PHY register 0 with bit 9 set stores it with bit 9 cleared and sets bit 5 of register 1. If `link_up` is high it also sets bit 2 of register 1 and bit 8 of register 5.
- R9: Configuration writes (select 1) update every bit except bits 9 and 8, which keep their value.
- R10: When `link_up` differs from its value in the previous cycle, register 1 bit 2 and register 5 bit 8 take the new level on the next edge, and the management status register becomes 0xFFFF. This takes priority over a same-cycle frame write to those bits.
- R11: A host read with select 2 clears the management status register on the next edge, unless a link change happens in the same cycle.
- R12: `host_rdata` shows the register chosen by `host_sel` without delay: 0 frame, 1 configuration, 2 management status zero-extended, 3 zero. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Current link level of the modelled PHY |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (used for read-clear) |
| host_sel | input | 2 | Register select: 0 frame, 1 config, 2 mgmt status, 3 none |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected register contents |

## Verification
The properties assume `host_sel` and `host_wdata` are meaningful only while `host_wr` or `host_rd` is high. They also assume `link_up` is a synchronous level that may change on any cycle, including the cycle of a frame write. The stimulus changes inputs two nanoseconds after the rising edge. It holds strobes for exactly one cycle, and in some cases it deliberately lines up a link toggle with a status read or a status-register write. That exercises the priority in R10 and R11 without breaking those assumptions.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int FRAME_W = 32;
  localparam int PHY_DW  = 16;
  localparam int FLD_AW  = 5;
  localparam int STAT_W  = 16;

  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_CFG   = 2'd1,
    SEL_MSTAT = 2'd2,
    SEL_NONE  = 2'd3
  } host_sel_e;

  typedef struct packed {
    logic [1:0]        st;
    logic [1:0]        op;
    logic [FLD_AW-1:0] phy;
    logic [FLD_AW-1:0] regad;
    logic [1:0]        ta;
    logic [PHY_DW-1:0] data;
  } frame_t;

  localparam logic [1:0] ST_GOOD = 2'b01;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;

  // PHY register numbers
  localparam int PR_CTRL = 0;
  localparam int PR_STAT = 1;
  localparam int PR_ID_H = 2;
  localparam int PR_ID_L = 3;
  localparam int PR_ADV  = 4;
  localparam int PR_PART = 5;

  // bit positions inside the PHY registers
  localparam int B_CTRL_RST  = 15;
  localparam int B_CTRL_ANEN = 12;
  localparam int B_CTRL_ANRS = 9;
  localparam int B_STAT_LINK = 2;
  localparam int B_STAT_ANAB = 3;
  localparam int B_STAT_ANOK = 5;
  localparam int B_STAT_FD   = 14;
  localparam int B_ABIL_FD   = 8;

  localparam int B_CFG_RO_LO = 8;
  localparam int B_CFG_RO_HI = 9;

  // control register value after the self-clearing bits are folded
  function automatic logic [PHY_DW-1:0] ctrl_fold(input logic [PHY_DW-1:0] d);
    logic [PHY_DW-1:0] r;
    r = d;
    if (d[B_CTRL_RST]) begin
      r[B_CTRL_RST]  = 1'b0;
      r[B_CTRL_ANEN] = 1'b1;
    end
    r[B_CTRL_ANRS] = 1'b0;
    return r;
  endfunction

  function automatic logic [PHY_DW-1:0] stat_init(input logic link);
    logic [PHY_DW-1:0] r;
    r = '0;
    r[B_STAT_ANAB] = 1'b1;
    r[B_STAT_ANOK] = 1'b1;
    r[B_STAT_FD]   = 1'b1;
    r[B_STAT_LINK] = link;
    return r;
  endfunction

  function automatic logic [PHY_DW-1:0] abil_word(input logic fd);
    logic [PHY_DW-1:0] r;
    r = '0;
    r[B_ABIL_FD] = fd;
    return r;
  endfunction

  function automatic logic [FRAME_W-1:0] cfg_merge(input logic [FRAME_W-1:0] wr,
                                                   input logic [FRAME_W-1:0] cur);
    logic [FRAME_W-1:0] r;
    r = wr;
    r[B_CFG_RO_HI:B_CFG_RO_LO] = cur[B_CFG_RO_HI:B_CFG_RO_LO];
    return r;
  endfunction

endpackage

// File: rtl/mgmt_frame_decode.sv
module mgmt_frame_decode
  import mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input  frame_t            frame_in,
  output logic              hit,
  output logic              do_wr,
  output logic              do_rd,
  output logic [FLD_AW-1:0] reg_idx
);
  localparam logic [FLD_AW-1:0] MY_ADDR = FLD_AW'(PHY_ADDR);

  always_comb begin
    hit     = (frame_in.st == ST_GOOD) && (frame_in.phy == MY_ADDR);
    do_wr   = hit && (frame_in.op == OP_WR);
    do_rd   = hit && (frame_in.op == OP_RD);
    reg_idx = frame_in.regad;
  end
endmodule

// File: rtl/mgmt_link_watch.sv
module mgmt_link_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  output logic link_q,
  output logic link_evt
);
  always_ff @(posedge clk) begin
    if (!rst_n) link_q <= link_in;
    else        link_q <= link_in;
  end

  assign link_evt = rst_n && (link_in != link_q);
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
  import mgmt_pkg::*;
#(
  parameter int              NREG  = 32,
  parameter logic [15:0]     ID_HI = 16'h2000,
  parameter logic [15:0]     ID_LO = 16'h5C01
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     link_in,
  input  logic                     link_evt,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [PHY_DW-1:0]        wr_data,
  input  logic [$clog2(NREG)-1:0]  rd_idx,
  output logic [PHY_DW-1:0]        rd_data,
  output logic [PHY_DW-1:0]        ctrl_word,
  output logic [PHY_DW-1:0]        status_word,
  output logic [PHY_DW-1:0]        partner_word
);
  localparam int IW = $clog2(NREG);

  logic [PHY_DW-1:0] regs [NREG];
  logic [PHY_DW-1:0] stat_n, part_n;
  logic              wr_ctrl, wr_stat, wr_part, restart;

  function automatic logic [PHY_DW-1:0] init_val(input int idx, input logic link);
    case (idx)
      PR_STAT: return stat_init(link);
      PR_ID_H: return ID_HI;
      PR_ID_L: return ID_LO;
      PR_ADV:  return abil_word(1'b1);
      PR_PART: return abil_word(link);
      default: return '0;
    endcase
  endfunction

  assign wr_ctrl = wr_en && (wr_idx == IW'(PR_CTRL));
  assign wr_stat = wr_en && (wr_idx == IW'(PR_STAT));
  assign wr_part = wr_en && (wr_idx == IW'(PR_PART));
  assign restart = wr_ctrl && wr_data[B_CTRL_ANRS];

  // status and partner words: host write, then restart side effect, then link
  always_comb begin
    stat_n = wr_stat ? wr_data : regs[PR_STAT];
    part_n = wr_part ? wr_data : regs[PR_PART];
    if (restart) begin
      stat_n[B_STAT_ANOK] = 1'b1;
      if (link_in) begin
        stat_n[B_STAT_LINK] = 1'b1;
        part_n[B_ABIL_FD]   = 1'b1;
      end
    end
    if (link_evt) begin
      stat_n[B_STAT_LINK] = link_in;
      part_n[B_ABIL_FD]   = link_in;
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == PR_STAT) begin : g_stat
        always_ff @(posedge clk) begin
          if (!rst_n) regs[g] <= init_val(g, link_in);
          else        regs[g] <= stat_n;
        end
      end else if (g == PR_PART) begin : g_part
        always_ff @(posedge clk) begin
          if (!rst_n) regs[g] <= init_val(g, link_in);
          else        regs[g] <= part_n;
        end
      end else if (g == PR_CTRL) begin : g_ctrl
        always_ff @(posedge clk) begin
          if (!rst_n)       regs[g] <= init_val(g, link_in);
          else if (wr_ctrl) regs[g] <= ctrl_fold(wr_data);
        end
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (!rst_n)                             regs[g] <= init_val(g, link_in);
          else if (wr_en && wr_idx == IW'(g))     regs[g] <= wr_data;
        end
      end
    end
  endgenerate

  assign rd_data      = regs[rd_idx];
  assign ctrl_word    = regs[PR_CTRL];
  assign status_word  = regs[PR_STAT];
  assign partner_word = regs[PR_PART];
endmodule

// File: rtl/mgmt_frame_port.sv
module mgmt_frame_port
  import mgmt_pkg::*;
#(
  parameter int          PHY_ADDR = 1,
  parameter int          NREG     = 32,
  parameter logic [15:0] ID_HI    = 16'h2000,
  parameter logic [15:0] ID_LO    = 16'h5C01,
  parameter logic [31:0] CFG_INIT = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  localparam int IW = $clog2(NREG);

  frame_t             frame_in, frame_n;
  logic [FRAME_W-1:0] frame_q, cfg_q;
  logic [STAT_W-1:0]  mstat_q;

  logic              frame_wr_evt, cfg_wr_evt, mstat_rd_evt;
  logic              hit, do_wr, do_rd, phy_wr;
  logic [FLD_AW-1:0] reg_idx;
  logic              link_q, link_evt;
  logic [PHY_DW-1:0] phy_rd_data, ctrl_word, status_word, partner_word;

  assign frame_in     = frame_t'(host_wdata);
  assign frame_wr_evt = host_wr && (host_sel == SEL_FRAME);
  assign cfg_wr_evt   = host_wr && (host_sel == SEL_CFG);
  assign mstat_rd_evt = host_rd && (host_sel == SEL_MSTAT);

  mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .frame_in (frame_in),
    .hit      (hit),
    .do_wr    (do_wr),
    .do_rd    (do_rd),
    .reg_idx  (reg_idx)
  );

  assign phy_wr = frame_wr_evt && do_wr;

  mgmt_link_watch u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_in  (link_up),
    .link_q   (link_q),
    .link_evt (link_evt)
  );

  mgmt_phy_regs #(.NREG(NREG), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_phy (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_in      (link_up),
    .link_evt     (link_evt),
    .wr_en        (phy_wr),
    .wr_idx       (IW'(reg_idx)),
    .wr_data      (frame_in.data),
    .rd_idx       (IW'(reg_idx)),
    .rd_data      (phy_rd_data),
    .ctrl_word    (ctrl_word),
    .status_word  (status_word),
    .partner_word (partner_word)
  );

  always_comb begin
    frame_n       = frame_in;
    frame_n.ta[0] = 1'b1;
    if (do_rd) frame_n.data = phy_rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      cfg_q   <= CFG_INIT;
      mstat_q <= '0;
    end else begin
      if (frame_wr_evt) frame_q <= frame_n;
      if (cfg_wr_evt)   cfg_q   <= cfg_merge(host_wdata, cfg_q);
      if (link_evt)          mstat_q <= '1;
      else if (mstat_rd_evt) mstat_q <= '0;
    end
  end

  always_comb begin
    case (host_sel)
      SEL_FRAME: host_rdata = frame_q;
      SEL_CFG:   host_rdata = cfg_q;
      SEL_MSTAT: host_rdata = FRAME_W'(mstat_q);
      default:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mgmt_frame_chk.sv
module mgmt_frame_chk #(
  parameter int PHY_ADDR = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        link_up,
  input logic        host_rd,
  input logic [1:0]  host_sel,
  input logic [31:0] host_wdata,
  input logic        frame_wr_evt,
  input logic        cfg_wr_evt,
  input logic        link_evt,
  input logic [31:0] frame_q,
  input logic [31:0] cfg_q,
  input logic [15:0] mstat_q,
  input logic [15:0] ctrl_word,
  input logic [15:0] status_word,
  input logic [15:0] partner_word
);
  logic good_frame, ctrl_wr;
  assign good_frame = frame_wr_evt && host_wdata[31:30] == 2'b01 &&
                      host_wdata[27:23] == 5'(PHY_ADDR);
  assign ctrl_wr = good_frame && host_wdata[29:28] == 2'b01 && host_wdata[22:18] == 5'd0;

  assert_frame_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wr_evt |=> frame_q[16]);

  assert_foreign_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr_evt && !good_frame) |=> $stable(ctrl_word));

  assert_ctrl_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && host_wdata[15]) |=> (!ctrl_word[15] && ctrl_word[12]));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && host_wdata[9]) |=> (!ctrl_word[9] && status_word[5]));

  assert_cfg_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_evt |=> cfg_q[9:8] == $past(cfg_q[9:8]));

  assert_link_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> (mstat_q == 16'hFFFF && status_word[2] == $past(link_up) &&
                  partner_word[8] == $past(link_up)));

  assert_mstat_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel == 2'd2 && !link_evt) |=> mstat_q == 16'h0);
endmodule

bind mgmt_frame_port mgmt_frame_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_up      (link_up),
  .host_rd      (host_rd),
  .host_sel     (host_sel),
  .host_wdata   (host_wdata),
  .frame_wr_evt (frame_wr_evt),
  .cfg_wr_evt   (cfg_wr_evt),
  .link_evt     (link_evt),
  .frame_q      (frame_q),
  .cfg_q        (cfg_q),
  .mstat_q      (mstat_q),
  .ctrl_word    (ctrl_word),
  .status_word  (status_word),
  .partner_word (partner_word)
);

// File: tb/tb_mgmt_frame_port.sv
module tb_mgmt_frame_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit model_ok = 0;

  // behavioural reference
  logic [15:0] m_phy [32];
  logic [31:0] m_frame, m_cfg;
  logic [15:0] m_stat;
  logic        m_link;

  always #5 clk = ~clk;

  mgmt_frame_port dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .host_wr(host_wr),
    .host_rd(host_rd), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h t=%0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_phy[i] = 16'h0;
      m_phy[1] = 16'h4028 | (link_up ? 16'h0004 : 16'h0);
      m_phy[2] = 16'h2000;
      m_phy[3] = 16'h5C01;
      m_phy[4] = 16'h0100;
      m_phy[5] = link_up ? 16'h0100 : 16'h0;
      m_frame = 0; m_cfg = 32'h100; m_stat = 0; m_link = link_up;
      model_ok = 1;
    end else begin
      bit evt;
      evt = (link_up != m_link);
      if (host_wr && host_sel == 2'd0) begin
        logic [31:0] v;
        int idx;
        logic [15:0] d;
        v = host_wdata;
        v[16] = 1'b1;
        idx = int'(host_wdata[22:18]);
        d = host_wdata[15:0];
        if (host_wdata[31:30] == 2'b01 && host_wdata[27:23] == 5'd1) begin
          if (host_wdata[29:28] == 2'b10) v[15:0] = m_phy[idx];
          else if (host_wdata[29:28] == 2'b01) begin
            if (idx == 0) begin
              if (d[15]) begin d[15] = 1'b0; d[12] = 1'b1; end
              if (d[9]) begin
                d[9] = 1'b0;
                m_phy[1][5] = 1'b1;
                if (link_up) begin m_phy[1][2] = 1'b1; m_phy[5][8] = 1'b1; end
              end
            end
            m_phy[idx] = d;
          end
        end
        m_frame = v;
      end
      if (host_wr && host_sel == 2'd1)
        m_cfg = {host_wdata[31:10], m_cfg[9:8], host_wdata[7:0]};
      if (host_rd && host_sel == 2'd2) m_stat = 0;
      if (evt) begin
        m_link = link_up;
        m_phy[1][2] = link_up;
        m_phy[5][8] = link_up;
        m_stat = 16'hFFFF;
      end
    end
  end

  always @(negedge clk) begin
    if (model_ok) begin
      logic [31:0] e;
      case (host_sel)
        2'd0: e = m_frame;
        2'd1: e = m_cfg;
        2'd2: e = {16'h0, m_stat};
        default: e = 0;
      endcase
      chk(cur_req, host_rdata, e);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic hwrite(input logic [1:0] sel, input logic [31:0] d);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] sel);
    host_rd = 1'b1; host_sel = sel;
    tick();
    host_rd = 1'b0;
  endtask

  task automatic frm(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                     input logic [4:0] ra, input logic [15:0] d);
    hwrite(2'd0, {st, op, phy, ra, 2'b00, d});
    tick();
  endtask

  task automatic phy_rd(input logic [4:0] ra);
    frm(2'b01, 2'b10, 5'd1, ra, 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    cur_req = "R1";
    hread(2'd1); hread(2'd2); host_sel = 2'd0; tick();
    for (int r = 0; r < 6; r++) phy_rd(5'(r));
    phy_rd(5'd1);
    @(negedge clk); chk("R1", {16'h0, host_rdata[15:0]}, 32'h0000_402C);
    tick();
    cur_req = "R4";
    frm(2'b01, 2'b01, 5'd1, 5'd4, 16'h01E1); phy_rd(5'd4);
    frm(2'b01, 2'b01, 5'd1, 5'd31, 16'hA5C3); phy_rd(5'd31);
    cur_req = "R5";
    hwrite(2'd0, {2'b01, 2'b10, 5'd1, 5'd31, 2'b00, 16'hFFFF});
    @(negedge clk); chk("R5", host_rdata, {2'b01, 2'b10, 5'd1, 5'd31, 2'b01, 16'hA5C3});
    tick();
    cur_req = "R2";
    frm(2'b00, 2'b01, 5'd1, 5'd4, 16'h1234);
    frm(2'b11, 2'b01, 5'd1, 5'd4, 16'h4321);
    frm(2'b10, 2'b01, 5'd1, 5'd0, 16'h8000);
    phy_rd(5'd4); phy_rd(5'd0);
    cur_req = "R3";
    frm(2'b01, 2'b01, 5'd0, 5'd4, 16'h1111);
    frm(2'b01, 2'b01, 5'd2, 5'd4, 16'h2222);
    frm(2'b01, 2'b01, 5'd31, 5'd0, 16'h8200);
    phy_rd(5'd4); phy_rd(5'd0);
    cur_req = "R6";
    frm(2'b01, 2'b00, 5'd1, 5'd4, 16'h3333);
    frm(2'b01, 2'b11, 5'd1, 5'd4, 16'h4444);
    phy_rd(5'd4);
    cur_req = "R7";
    frm(2'b01, 2'b01, 5'd1, 5'd0, 16'h8000); phy_rd(5'd0);
    frm(2'b01, 2'b01, 5'd1, 5'd0, 16'h8140); phy_rd(5'd0);
    cur_req = "R8";
    frm(2'b01, 2'b01, 5'd1, 5'd1, 16'h0000);
    frm(2'b01, 2'b01, 5'd1, 5'd5, 16'h0000);
    frm(2'b01, 2'b01, 5'd1, 5'd0, 16'h0200);
    phy_rd(5'd0); phy_rd(5'd1); phy_rd(5'd5);
    cur_req = "R10";
    link_up = 1'b0; tick();
    host_sel = 2'd2; tick();
    phy_rd(5'd1); phy_rd(5'd5);
    cur_req = "R11";
    hread(2'd2); tick();
    cur_req = "R8";
    frm(2'b01, 2'b01, 5'd1, 5'd1, 16'h0000);
    frm(2'b01, 2'b01, 5'd1, 5'd0, 16'h1200);
    phy_rd(5'd1); phy_rd(5'd5);
    cur_req = "R10";
    link_up = 1'b1;
    hwrite(2'd0, {2'b01, 2'b01, 5'd1, 5'd1, 2'b00, 16'h0000});
    phy_rd(5'd1); phy_rd(5'd5);
    cur_req = "R11";
    link_up = 1'b0;
    hread(2'd2); host_sel = 2'd2; tick();
    hread(2'd2); tick();
    cur_req = "R9";
    hwrite(2'd1, 32'hFFFF_FCFF); tick();
    hwrite(2'd1, 32'h0000_0200); tick();
    hwrite(2'd1, 32'h1234_5678); tick();
    cur_req = "R12";
    hwrite(2'd3, 32'hFFFF_FFFF); tick();
    host_sel = 2'd0; tick(); host_sel = 2'd1; tick(); host_sel = 2'd2; tick();
    cur_req = "R5";
    frm(2'b01, 2'b01, 5'd1, 5'd7, 16'h0F0F);
    phy_rd(5'd7); phy_rd(5'd2); phy_rd(5'd3);
    cur_req = "R1";
    link_up = 1'b0; rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    phy_rd(5'd1); phy_rd(5'd5); host_sel = 2'd1; tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule